// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer whose control register only accepts writes that follow fixed key words. A free-running counter advances every clock. When the counter bit chosen by a timeout select field rises, the watchdog has expired. If both the watchdog and its reset action are enabled, the block pulses a system-reset request and sets a sticky flag that records the watchdog as the cause of the reset.

Software keeps the system alive by writing a two-word restart key to the control register, which clears the counter. To change the settings it writes a two-word unlock key, and the next control write is then taken as the new configuration. Any write that breaks a key sequence throws the partial sequence away. While the echo-mode input is high, every control write is dropped. A second write target, the status word, clears the sticky cause flag when a one is written to its bit 0.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, cfg_en, cfg_rst_en, cfg_sel, wdt_cause and rst_req are all zero.
- R2: A control write of UNL_KEY_A, then one of UNL_KEY_B, arms the block. The next control write loads the configuration and clears the counter. The new settings show on the outputs one cycle after the loading edge.
- R3: The configuration word uses bit 15 as the enable, bit 14 as the reset enable and bits 2:0 as the select. With the counter cleared at edge E and both enables set, rst_req is high for exactly one cycle, starting at edge E + 2^(EXP_LO+sel) + 1.
- R4: A control write of RST_KEY_A, then one of RST_KEY_B, clears the counter. Expiry is then measured from the edge that accepted RST_KEY_B.
- R5: While cfg_en is 0, rst_req never rises. The reset enable and the select are still stored and visible.
- R6: While cfg_rst_en is 0, an expiry raises neither rst_req nor wdt_cause.
- R7: wdt_cause is set on the same edge as rst_req and stays set afterwards. A status write (wr_addr=1) with bit 0 set clears it. A status write with bit 0 clear leaves it set.
- R8: A control write that does not continue the pending sequence leaves the configuration unchanged and returns the key logic to idle. Status writes in the middle of a sequence do the same. A key in the wrong order leaves both the configuration and the counter unchanged.
- R9: A write of a first key word starts a new sequence from any unarmed state, so a repeated first key still lets the sequence complete.
- R10: While echo_mode is 1, control writes change nothing: not the configuration, not the counter, not the progress of a key sequence.
- R11: A select value of NUM_SEL or above is stored as NUM_SEL-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 selects control, 1 selects status |
| wr_data | input | 16 | Write data |
| echo_mode | input | 1 | When high, control writes are blocked |
| cfg_en | output | 1 | Stored watchdog enable |
| cfg_rst_en | output | 1 | Stored reset-on-expiry enable |
| cfg_sel | output | 3 | Stored timeout select |
| wdt_cause | output | 1 | Sticky flag: the last reset came from the watchdog |
| rst_req | output | 1 | One-cycle system-reset request |

## Verification
The bench builds the block with a 10-bit counter and EXP_LO=2, so the six timeouts are 4 to 128 cycles instead of seconds. With timeouts this short, every select value can be run to expiry, including the clamped top setting. A restart landing a few cycles before expiry shows that the deadline moves. Runs of 40 cycles with the enables cleared cover several counter-bit rises, each of which must produce no request. The keys keep their default values, so the sequence checks use the same words the block has at its defaults.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int          CNT_W     = 32,
  parameter int          EXP_LO    = 25,
  parameter int          NUM_SEL   = 6,
  parameter logic [15:0] RST_KEY_A = 16'hAAAA,
  parameter logic [15:0] RST_KEY_B = 16'h5555,
  parameter logic [15:0] UNL_KEY_A = 16'h3333,
  parameter logic [15:0] UNL_KEY_B = 16'hCCCC,
  localparam int         SEL_W     = $clog2(NUM_SEL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [15:0]      wr_data,
  input  logic             echo_mode,
  output logic             cfg_en,
  output logic             cfg_rst_en,
  output logic [SEL_W-1:0] cfg_sel,
  output logic             wdt_cause,
  output logic             rst_req
);

  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NUM_SEL - 1);

  typedef enum logic [1:0] {S_IDLE, S_RST1, S_UNL1, S_ARMED} seq_t;

  seq_t             seq_q, seq_d;
  logic             do_restart, do_load;
  logic [CNT_W-1:0] cnt_q, cnt_shift;
  logic             tap, tap_q, expire;
  logic [SEL_W-1:0] new_sel;

  wire ctl_wr  = wr_en && !wr_addr && !echo_mode;
  wire stat_wr = wr_en && wr_addr;

  function automatic seq_t first_key(input logic [15:0] d);
    if (d == RST_KEY_A)      return S_RST1;
    else if (d == UNL_KEY_A) return S_UNL1;
    else                     return S_IDLE;
  endfunction

  always_comb begin
    seq_d      = seq_q;
    do_restart = 1'b0;
    do_load    = 1'b0;
    if (stat_wr) begin
      seq_d = S_IDLE;
    end else if (ctl_wr) begin
      case (seq_q)
        S_ARMED: begin
          do_load = 1'b1;
          seq_d   = S_IDLE;
        end
        S_RST1:
          if (wr_data == RST_KEY_B) begin
            do_restart = 1'b1;
            seq_d      = S_IDLE;
          end else begin
            seq_d = first_key(wr_data);
          end
        S_UNL1:
          if (wr_data == UNL_KEY_B) seq_d = S_ARMED;
          else                      seq_d = first_key(wr_data);
        default: seq_d = first_key(wr_data);
      endcase
    end
  end

  assign new_sel   = (wr_data[SEL_W-1:0] > SEL_MAX) ? SEL_MAX : wr_data[SEL_W-1:0];
  assign cnt_shift = cnt_q >> (EXP_LO + int'(cfg_sel));
  assign tap       = cnt_shift[0];
  assign expire    = tap && !tap_q && cfg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q      <= S_IDLE;
      cnt_q      <= '0;
      tap_q      <= 1'b0;
      cfg_en     <= 1'b0;
      cfg_rst_en <= 1'b0;
      cfg_sel    <= '0;
      rst_req    <= 1'b0;
      wdt_cause  <= 1'b0;
    end else begin
      seq_q   <= seq_d;
      tap_q   <= tap;
      cnt_q   <= (do_restart || do_load) ? '0 : cnt_q + 1'b1;
      rst_req <= expire && cfg_rst_en;
      if (do_load) begin
        cfg_en     <= wr_data[15];
        cfg_rst_en <= wr_data[14];
        cfg_sel    <= new_sel;
      end
      if (expire && cfg_rst_en)       wdt_cause <= 1'b1;
      else if (stat_wr && wr_data[0]) wdt_cause <= 1'b0;
    end
  end

endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int NUM_SEL = 6,
  parameter int SEL_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_addr,
  input logic [15:0]      wr_data,
  input logic             echo_mode,
  input logic             cfg_en,
  input logic             cfg_rst_en,
  input logic [SEL_W-1:0] cfg_sel,
  input logic             wdt_cause,
  input logic             rst_req
);

  assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !rst_req);

  assert_noreset_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rst_en |=> !rst_req);

  assert_req_sets_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> wdt_cause);

  assert_cause_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_cause) |-> $past(wr_en && wr_addr && wr_data[0]));

  assert_echo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && echo_mode) |=> $stable({cfg_en, cfg_rst_en, cfg_sel}));

  assert_sel_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cfg_sel) <= NUM_SEL - 1);

endmodule

bind keyed_wdt keyed_wdt_chk #(.NUM_SEL(NUM_SEL), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .echo_mode(echo_mode), .cfg_en(cfg_en), .cfg_rst_en(cfg_rst_en), .cfg_sel(cfg_sel),
  .wdt_cause(wdt_cause), .rst_req(rst_req)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;

  localparam logic [15:0] RKA = 16'hAAAA, RKB = 16'h5555;
  localparam logic [15:0] UKA = 16'h3333, UKB = 16'hCCCC;
  localparam int K_CFG = 0, K_CAUSE = 1, K_REQ = 2;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, wr_addr = 0, echo_mode = 0;
  logic [15:0] wr_data = '0;
  logic        cfg_en, cfg_rst_en, wdt_cause, rst_req;
  logic [2:0]  cfg_sel;

  int cyc = 0, n_chk = 0, n_fail = 0;

  typedef struct { int cyc; int kind; int exp; string tag; } item_t;
  item_t q[$];

  keyed_wdt #(.CNT_W(10), .EXP_LO(2), .NUM_SEL(6),
    .RST_KEY_A(RKA), .RST_KEY_B(RKB), .UNL_KEY_A(UKA), .UNL_KEY_B(UKB)) u_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .echo_mode(echo_mode), .cfg_en(cfg_en), .cfg_rst_en(cfg_rst_en), .cfg_sel(cfg_sel),
    .wdt_cause(wdt_cause), .rst_req(rst_req));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pops the expected items due this cycle and compares
  always @(negedge clk) begin
    bit pulse_ok;
    pulse_ok = 0;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        int act;
        case (q[i].kind)
          K_CFG:   act = int'({cfg_en, cfg_rst_en, cfg_sel});
          K_CAUSE: act = int'(wdt_cause);
          default: act = int'(rst_req);
        endcase
        n_chk++;
        if (act != q[i].exp) begin
          n_fail++;
          $display("FAIL %s cycle %0d kind %0d: actual %0d expected %0d",
                   q[i].tag, cyc, q[i].kind, act, q[i].exp);
        end
        if (q[i].kind == K_REQ && q[i].exp == 1) pulse_ok = 1;
        q.delete(i);
      end
    end
    if (rst_n && rst_req && !pulse_ok) begin
      n_chk++;
      n_fail++;
      $display("FAIL R3 unexpected rst_req at cycle %0d: actual 1 expected 0", cyc);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual running expected done");
    summary();
  end

  function automatic int ce(bit en, bit ren, int sel);
    return en * 16 + ren * 8 + sel;
  endfunction

  function automatic logic [15:0] cw(bit en, bit ren, int sel);
    return {en, ren, 11'b0, 3'(sel)};
  endfunction

  task automatic expect_at(int c, int kind, int exp, string tag);
    item_t it;
    it.cyc = c; it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit addr, logic [15:0] d);
    wr_en = 1; wr_addr = addr; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_addr = 0; wr_data = '0;
  endtask

  task automatic load(bit en, bit ren, int sel);
    wr(0, UKA); wr(0, UKB); wr(0, cw(en, ren, sel));
  endtask

  task automatic restart();
    wr(0, RKA); wr(0, RKB);
  endtask

  task automatic quiet_and_clear();
    load(0, 0, 0);
    wr(1, 16'h0001);
    idle(2);
  endtask

  initial begin
    int e, r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    expect_at(cyc + 1, K_CFG, 0, "R1");
    expect_at(cyc + 1, K_CAUSE, 0, "R1");
    expect_at(cyc + 1, K_REQ, 0, "R1");
    idle(1);

    // R2/R3 load and expire with sel=2 (16 cycles)
    load(1, 1, 2); e = cyc;
    expect_at(e + 1, K_CFG, ce(1, 1, 2), "R2");
    expect_at(e + 16, K_REQ, 0, "R3");
    expect_at(e + 17, K_REQ, 1, "R3");
    expect_at(e + 17, K_CAUSE, 1, "R7");
    expect_at(e + 18, K_REQ, 0, "R3");
    idle(20);
    wr(1, 16'h0000);
    expect_at(cyc + 1, K_CAUSE, 1, "R7");
    idle(1);
    wr(1, 16'h0001);
    expect_at(cyc + 1, K_CAUSE, 0, "R7");
    idle(1);
    load(0, 1, 2);
    idle(2);

    // R4 restart moves the deadline
    load(1, 1, 1); e = cyc;
    idle(4);
    restart(); r = cyc;
    expect_at(e + 9, K_REQ, 0, "R4");
    expect_at(r + 9, K_REQ, 1, "R4");
    idle(12);
    quiet_and_clear();

    // R5 disabled: settings stored, no request
    load(0, 1, 0); e = cyc;
    expect_at(e + 1, K_CFG, ce(0, 1, 0), "R5");
    expect_at(e + 5, K_REQ, 0, "R5");
    idle(40);
    expect_at(cyc + 1, K_CAUSE, 0, "R5");
    idle(1);

    // R6 reset action off: expiry makes no request, no cause
    load(1, 0, 0); e = cyc;
    expect_at(e + 5, K_REQ, 0, "R6");
    expect_at(e + 6, K_CAUSE, 0, "R6");
    idle(20);
    expect_at(cyc + 1, K_CAUSE, 0, "R6");
    idle(1);

    // R8 broken sequences leave configuration alone
    load(0, 0, 3);
    expect_at(cyc + 1, K_CFG, ce(0, 0, 3), "R8");
    idle(1);
    wr(0, UKB); wr(0, UKA); wr(0, cw(1, 1, 4));
    expect_at(cyc + 1, K_CFG, ce(0, 0, 3), "R8");
    idle(1);
    wr(0, UKA); wr(1, 16'h0000); wr(0, UKB); wr(0, cw(1, 1, 4));
    expect_at(cyc + 1, K_CFG, ce(0, 0, 3), "R8");
    idle(1);
    wr(0, UKA); wr(0, RKA); wr(0, UKB); wr(0, cw(1, 1, 4));
    expect_at(cyc + 1, K_CFG, ce(0, 0, 3), "R8");
    idle(1);
    load(1, 1, 2); e = cyc;
    idle(3);
    wr(0, RKB); wr(0, RKA);
    expect_at(e + 17, K_REQ, 1, "R8");
    idle(20);
    quiet_and_clear();

    // R9 repeated first key restarts the sequence
    wr(0, UKA); wr(0, UKA); wr(0, UKB); wr(0, cw(0, 1, 4));
    expect_at(cyc + 1, K_CFG, ce(0, 1, 4), "R9");
    idle(1);
    load(1, 1, 1); e = cyc;
    idle(3);
    wr(0, RKA); wr(0, RKA); wr(0, RKB); r = cyc;
    expect_at(e + 9, K_REQ, 0, "R9");
    expect_at(r + 9, K_REQ, 1, "R9");
    idle(12);
    quiet_and_clear();

    // R10 echo mode blocks control writes
    echo_mode = 1;
    load(1, 1, 0);
    echo_mode = 0;
    expect_at(cyc + 1, K_CFG, ce(0, 0, 0), "R10");
    idle(1);
    wr(0, UKA);
    echo_mode = 1;
    wr(0, UKB);
    echo_mode = 0;
    wr(0, cw(1, 1, 0));
    expect_at(cyc + 1, K_CFG, ce(0, 0, 0), "R10");
    idle(1);
    load(1, 1, 3); e = cyc;
    idle(5);
    echo_mode = 1;
    restart();
    echo_mode = 0;
    expect_at(e + 33, K_REQ, 1, "R10");
    idle(36 - (cyc - e));
    quiet_and_clear();

    // R11 select clamp, longest timeout
    load(0, 0, 7);
    expect_at(cyc + 1, K_CFG, ce(0, 0, 5), "R11");
    idle(1);
    load(1, 1, 7); e = cyc;
    expect_at(e + 128, K_REQ, 0, "R11");
    expect_at(e + 129, K_REQ, 1, "R11");
    idle(150);
    expect_at(cyc + 1, K_CAUSE, 1, "R7");
    idle(1);
    quiet_and_clear();

    idle(3);
    if (q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d items left expected 0", q.size());
    end
    summary();
  end

endmodule